// File: doc/BRIEF.md
# Tile Colour Frame Buffer with Scan-Priority Port Sharing

This block stores one 3-bit colour per 8×8 pixel tile for a 640-pixel-wide raster and lets two users share a single-port RAM: the video scan, which reads a tile for every pixel, and a drawing engine, which writes tiles. The scan always wins while the raster is in the visible area. The drawing engine can only reach the RAM while the blank flag is high.

The scan side presents the pixel column, pixel row and blank flag from an external timing generator. The block turns the coordinates into a tile index and reads that tile. One clock later it drives the red, green and blue lines, and it forces them to zero for pixels that arrive while blanked. The drawing side raises a request with a tile index and a colour and holds them until it sees the acknowledge. The acknowledge is given in the same cycle the write is done, and only while blanked.

The memory holds 4096 words and starts all black. The 80×50 visible tiles use indices 0 to 3999.

Top module: `tile_fb_arbiter`

## Requirements
- R1: In active video the colour shown for pixel (x, y) is the one stored at index ((y >> 3) * 80 + (x >> 3)) mod 4096. All 64 pixels of a tile show the same colour, and a row of tiles is 80 entries long.
- R2: A stored word maps bit 2 to red, bit 1 to green and bit 0 to blue. For example, 3'b110 gives red 1, green 1, blue 0.
- R3: If blank is high in a cycle, all three colour outputs are 0 after the following clock edge.
- R4: Colour outputs change only at a clock edge. They show the tile addressed by the coordinates of the previous cycle, so the read latency is one cycle.
- R5: While blank is low, wr_ack stays 0 and no write reaches the memory. A pending request leaves the displayed colour of its target tile unchanged.
- R6: While blank is high and wr_req is high, wr_ack is 1 in that same cycle and wr_data is written to wr_addr at the next clock edge.
- R7: A request raised during active video and held is acknowledged in the first blanked cycle. Its colour is displayed from then on.
- R8: After reset the colour outputs are 0 and every tile reads as black (3'b000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| blank | input | 1 | High outside the visible area |
| wr_req | input | 1 | Drawing write request, held until acknowledged |
| wr_addr | input | 12 | Tile index to write |
| wr_data | input | 3 | Colour to write, bit 2 red, bit 1 green, bit 0 blue |
| wr_ack | output | 1 | Write is performed at this clock edge |
| vga_r | output | 1 | Red output |
| vga_g | output | 1 | Green output |
| vga_b | output | 1 | Blue output |

## Verification
A faulty index calculation or port selection shows up at the colour outputs one cycle after the coordinates are presented, as a colour from a neighbouring or unrelated tile. This is caught by comparing against a tile model kept in the bench after random writes. A write that leaks into active video changes a tile that is on screen while its request is still unacknowledged, and the colour check in the next cycle reports it. A stale or missing blank delay appears as a non-zero colour one cycle after a blanked pixel.

// File: rtl/tile_fb_pkg.sv
package tile_fb_pkg;
    localparam int COORD_W       = 10;
    localparam int TILE_SHIFT    = 3;
    localparam int TILES_PER_ROW = 80;
    localparam int ADDR_W        = 12;
    localparam int DEPTH         = 1 << ADDR_W;
    localparam int COLOR_W       = 3;

    typedef logic [ADDR_W-1:0]  tile_addr_t;
    typedef logic [COLOR_W-1:0] tile_color_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    typedef struct packed {
        tile_addr_t  addr;
        logic        we;
        tile_color_t wdata;
    } ram_cmd_t;

    function automatic rgb_t unpack_color(input tile_color_t c);
        rgb_t o;
        o.r = c[2];
        o.g = c[1];
        o.b = c[0];
        return o;
    endfunction
endpackage

// File: rtl/tile_addr_map.sv
module tile_addr_map
    import tile_fb_pkg::*;
#(
    parameter int CW     = COORD_W,
    parameter int AW     = ADDR_W,
    parameter int SHIFT  = TILE_SHIFT,
    parameter int ROW_LEN = TILES_PER_ROW
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic [AW-1:0] addr
);
    logic [CW-1:0] col;
    logic [CW-1:0] row;

    always_comb begin
        col  = x >> SHIFT;
        row  = y >> SHIFT;
        addr = AW'(row) * AW'(ROW_LEN) + AW'(col);
    end
endmodule

// File: rtl/fb_port_arb.sv
module fb_port_arb
    import tile_fb_pkg::*;
(
    input  logic        blank,
    input  tile_addr_t  disp_addr,
    input  logic        wr_req,
    input  tile_addr_t  wr_addr,
    input  tile_color_t wr_data,
    output ram_cmd_t    cmd,
    output logic        wr_ack
);
    logic scan_priority;

    always_comb begin
        scan_priority = ~blank;
        cmd.wdata     = wr_data;
        if (scan_priority) begin
            cmd.addr = disp_addr;
            cmd.we   = 1'b0;
        end else begin
            cmd.addr = wr_req ? wr_addr : disp_addr;
            cmd.we   = wr_req;
        end
        wr_ack = cmd.we;
    end

    always_comb begin
        assert_ack_has_req_R6: assert (!wr_ack || wr_req)
            else $error("ack without request");
    end
endmodule

// File: rtl/fb_spram.sv
module fb_spram #(
    parameter int AW    = 12,
    parameter int DW    = 3,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/fb_pixel_out.sv
module fb_pixel_out
    import tile_fb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        blank,
    input  tile_color_t rdata,
    output rgb_t        rgb
);
    logic blank_q;

    always_ff @(posedge clk) begin
        if (rst) blank_q <= 1'b1;
        else     blank_q <= blank;
    end

    always_comb rgb = blank_q ? '0 : unpack_color(rdata);

    assert_dark_after_blank_R3: assert property (@(posedge clk) disable iff (rst)
        blank |=> (rgb == '0));
    assert_dark_after_reset_R8: assert property (@(posedge clk)
        rst |=> (rgb == '0));
endmodule

// File: rtl/tile_fb_arbiter.sv
module tile_fb_arbiter
    import tile_fb_pkg::*;
#(
    parameter int CW      = COORD_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = COLOR_W,
    parameter int ROW_LEN = TILES_PER_ROW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic          blank,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ack,
    output logic          vga_r,
    output logic          vga_g,
    output logic          vga_b
);
    localparam int DEPTH_L = 1 << AW;

    tile_addr_t  disp_addr;
    ram_cmd_t    cmd;
    tile_color_t rdata;
    rgb_t        rgb;

    tile_addr_map #(.CW(CW), .AW(AW), .SHIFT(TILE_SHIFT), .ROW_LEN(ROW_LEN)) u_map (
        .x(pix_x), .y(pix_y), .addr(disp_addr)
    );

    fb_port_arb u_arb (
        .blank(blank), .disp_addr(disp_addr), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd), .wr_ack(wr_ack)
    );

    fb_spram #(.AW(AW), .DW(DW), .DEPTH(DEPTH_L)) u_ram (
        .clk(clk), .we(cmd.we), .addr(cmd.addr), .wdata(cmd.wdata), .rdata(rdata)
    );

    fb_pixel_out u_out (
        .clk(clk), .rst(rst), .blank(blank), .rdata(rdata), .rgb(rgb)
    );

    assign vga_r = rgb.r;
    assign vga_g = rgb.g;
    assign vga_b = rgb.b;

    assert_no_write_active_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.we |-> blank);
    assert_scan_addr_R1: assert property (@(posedge clk) disable iff (rst)
        !blank |-> (cmd.addr == AW'(AW'(pix_y / 8) * AW'(ROW_LEN) + AW'(pix_x / 8))));
    assert_write_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (blank && wr_req) |-> (cmd.we && cmd.addr == wr_addr));
endmodule

// File: tb/tile_fb_arbiter_tb.sv
module tile_fb_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] pix_x, pix_y;
    logic       blank;
    logic       wr_req;
    logic [11:0] wr_addr;
    logic [2:0] wr_data;
    logic       wr_ack;
    logic       vga_r, vga_g, vga_b;

    int tests = 0;
    int fails = 0;
    logic [2:0] model [4096];

    always #10 clk = ~clk;

    tile_fb_arbiter u_dut (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .blank(blank),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
    );

    function automatic logic [11:0] tile_of(input int x, input int y);
        int a;
        a = (y / 8) * 80 + (x / 8);
        return 12'(a % 4096);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic show(input string req, input int x, input int y, input logic b);
        @(negedge clk);
        pix_x = 10'(x); pix_y = 10'(y); blank = b;
        @(posedge clk); #1;
        check(req, {vga_r, vga_g, vga_b}, b ? 0 : int'(model[tile_of(x, y)]));
    endtask

    task automatic write_tile(input string req, input logic [11:0] a, input logic [2:0] d);
        @(negedge clk);
        blank = 1'b1; wr_req = 1'b1; wr_addr = a; wr_data = d;
        #1 check(req, wr_ack, 1);
        @(posedge clk); #1;
        model[a] = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) model[i] = 3'b000;
        rst = 1'b1; pix_x = '0; pix_y = '0; blank = 1'b0;
        wr_req = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk); #1;
        check("R8 reset colour", {vga_r, vga_g, vga_b}, 0);
        @(negedge clk); rst = 1'b0;

        // R8: memory starts black
        show("R8 black tile", 100, 200, 1'b0);
        show("R8 black last tile", 639, 399, 1'b0);

        // R2: bit order
        write_tile("R6 ack", 12'd0, 3'b110);
        show("R2 colour 110", 3, 5, 1'b0);
        check("R2 red", vga_r, 1); check("R2 green", vga_g, 1); check("R2 blue", vga_b, 0);
        write_tile("R6 ack", 12'd1, 3'b001);
        show("R2 colour 001", 8, 0, 1'b0);
        check("R2 blue only", {vga_r, vga_g, vga_b}, 1);

        // R1: tile corners and row stride
        write_tile("R6 ack", 12'd80, 3'b011);
        write_tile("R6 ack", 12'd3999, 3'b101);
        show("R1 tile 0 corner", 7, 7, 1'b0);
        show("R1 row stride", 0, 8, 1'b0);
        show("R1 row stride edge", 7, 15, 1'b0);
        show("R1 last visible tile", 639, 399, 1'b0);

        // R3: blanked pixel is dark even on lit tile
        show("R3 blank dark", 0, 0, 1'b1);
        show("R3 recover", 0, 0, 1'b0);

        // R4: output holds until the edge
        @(negedge clk);
        pix_x = 10'd8; pix_y = 10'd0; blank = 1'b0;
        #5 check("R4 old value before edge", {vga_r, vga_g, vga_b}, 6);
        @(posedge clk); #1;
        check("R4 new value after edge", {vga_r, vga_g, vga_b}, 1);

        // R5/R7: request held during active video
        @(negedge clk);
        pix_x = 10'd16; pix_y = 10'd8; blank = 1'b0;
        wr_req = 1'b1; wr_addr = tile_of(16, 8); wr_data = 3'b111;
        for (int k = 0; k < 5; k++) begin
            #1 check("R5 no ack in active", wr_ack, 0);
            @(posedge clk); #1;
            check("R5 tile unchanged", {vga_r, vga_g, vga_b}, 0);
            @(negedge clk);
        end
        blank = 1'b1;
        #1 check("R7 ack on first blank", wr_ack, 1);
        @(posedge clk); #1;
        model[tile_of(16, 8)] = 3'b111;
        @(negedge clk); wr_req = 1'b0;
        show("R7 colour visible", 20, 12, 1'b0);

        // random traffic
        for (int n = 0; n < 300; n++) begin
            write_tile("R6 random ack", 12'($urandom_range(0, 3999)), 3'($urandom_range(0, 7)));
        end
        for (int n = 0; n < 600; n++) begin
            show("R1 random pixel", $urandom_range(0, 639), $urandom_range(0, 399),
                 ($urandom_range(0, 7) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule